// File: doc/BRIEF.md
# Banked Clock Fanout with Per-Bank Divide and Enable

This block takes one reference clock and fans it out to four banks of output pins, called A, B, C and D, with a configurable number of identical pins per bank. Each bank has its own rate select, which picks either the reference clock itself or a half-rate copy made by a single shared toggle flip-flop. Because all half-rate banks take their signal from the same flip-flop, they always run in phase with one another.

A two-bit bank-enable code sets how many banks drive their pins, from one to four. The banks always switch on in the order A, B, C, D. One active-low pin does two jobs. While it is low, it clears the shared divider and puts every pin into high impedance. When it goes high, the outputs start running. Each pin has a separate output-enable signal at the ports, so the high-impedance state can be seen without resolving tri-state nets. A driven-value port and a tri-state pad port are also provided.

Top module: `clk_bank_fanout`

## Requirements
- R1: Every bank drives OUTS_PER_BANK pins, and all pins of a bank carry the same value and enable. Bank b occupies flat indices b*OUTS_PER_BANK to b*OUTS_PER_BANK+OUTS_PER_BANK-1, with bank A at index 0.
- R2: When an enabled bank has its select bit divSel[b] = 1, its pins follow refClk combinationally, with no register in the path.
- R3: When an enabled bank has divSel[b] = 0, its pins carry a half-rate clock. This clock is low until the first rising edge of refClk after rstOeN goes high, goes high on that edge, and then inverts on every rising edge. All half-rate banks share this phase.
- R4: While rstOeN is low, every clkOutEn bit is 0 and every clkOutVal bit is 0, whatever the code and select inputs are, and the divider is held cleared.
- R5: While rstOeN is high, bankEnCode (bit 1 = high bit, bit 0 = low bit) enables the banks as follows: 2'b00 enables A; 2'b10 enables A and B; 2'b01 enables A, B and C; 2'b11 enables all four. Bank A is enabled whenever rstOeN is high.
- R6: A bank that is not enabled has clkOutEn = 0 and clkOutVal = 0 on all of its pins.
- R7: Changing divSel while running changes the bank's rate at once, with no reset needed. A bank that moves to half rate picks up the running shared phase.
- R8: clkPad equals clkOutVal on every pin whose clkOutEn is 1, and is high impedance on every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock |
| rstOeN | input | 1 | Active-low divider reset and global output disable |
| bankEnCode | input | 2 | Bank count code, decoded as in R5 |
| divSel | input | 4 | Per-bank rate select, bit b for bank b: 1 selects full rate, 0 selects half rate |
| clkOutEn | output | 4*OUTS_PER_BANK | Per-pin output enable |
| clkOutVal | output | 4*OUTS_PER_BANK | Per-pin driven value, 0 when disabled |
| clkPad | output | 4*OUTS_PER_BANK | Tri-state pad output |

## Verification
The embedded assertions check on every clock cycle that the half-rate flip-flop inverts on each edge after release, that the enabled banks always form a prefix starting at bank A, that nothing is enabled during reset, and that disabled pins stay low and pins within a bank match. Only the bench's scenarios can show that each enable code selects the correct number of banks, that the full-rate path follows both phases of the clock, that the half-rate phase after release is correct, and that a rate change in the middle of a run takes effect immediately. The bench does this by comparing every pin against a counting reference model at both clock levels.

// File: rtl/clk_bank_fanout_pkg.sv
package clk_bank_fanout_pkg;
  localparam int NUM_BANKS = 4;
  localparam int CODE_W    = 2;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankOn;    // bank drives its pins
    logic [NUM_BANKS-1:0] fullRate;  // bank passes refClk straight through
  } fanoutCtrl_t;

  // number of live banks for a given enable code (order A,B,C,D)
  function automatic int activeCount(input logic [CODE_W-1:0] code);
    case (code)
      2'b00:   return 1;
      2'b10:   return 2;
      2'b01:   return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/fanout_ctrl.sv
module fanout_ctrl
  import clk_bank_fanout_pkg::*;
(
  input  logic              refClk,
  input  logic              rstOeN,
  input  logic [CODE_W-1:0] bankEnCode,
  input  logic [NUM_BANKS-1:0] divSel,
  output fanoutCtrl_t       ctrl
);
  int liveBanks;

  always_comb liveBanks = activeCount(bankEnCode);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      ctrl.bankOn[b]   = rstOeN && (b < liveBanks);
      ctrl.fullRate[b] = divSel[b];
    end
  end

  // R5: enabled banks form a prefix starting at bank A
  always_comb begin
    if (rstOeN) begin
      bankPrefix_chk: assert ((ctrl.bankOn & (ctrl.bankOn + 1'b1)) == '0);
    end
  end

  // R5
  bankAOn_chk: assert property (@(posedge refClk) disable iff (!rstOeN)
    ctrl.bankOn[0]);
endmodule

// File: rtl/fanout_datapath.sv
module fanout_datapath
  import clk_bank_fanout_pkg::*;
#(
  parameter int OUTS_PER_BANK = 5,
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                refClk,
  input  logic                rstOeN,
  input  fanoutCtrl_t         ctrl,
  output logic [NUM_OUTS-1:0] outEn,
  output logic [NUM_OUTS-1:0] outVal
);
  logic                 halfPhase;
  logic [NUM_BANKS-1:0] bankSrc;

  // shared half-rate toggle, cleared asynchronously by the reset pin
  always_ff @(posedge refClk or negedge rstOeN) begin
    if (!rstOeN) halfPhase <= 1'b0;
    else         halfPhase <= ~halfPhase;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb bankSrc[b] = ctrl.fullRate[b] ? refClk : halfPhase;
    for (genvar k = 0; k < OUTS_PER_BANK; k++) begin : g_pin
      always_comb begin
        outEn[b*OUTS_PER_BANK+k]  = ctrl.bankOn[b];
        outVal[b*OUTS_PER_BANK+k] = ctrl.bankOn[b] & bankSrc[b];
      end
      // R1
      pinMatch_chk: assert property (@(posedge refClk) disable iff (!rstOeN)
        (outVal[b*OUTS_PER_BANK+k] == outVal[b*OUTS_PER_BANK]) &&
        (outEn[b*OUTS_PER_BANK+k] == outEn[b*OUTS_PER_BANK]));
    end
  end

  // R3
  halfToggle_chk: assert property (@(posedge refClk) disable iff (!rstOeN)
    $past(rstOeN) |-> halfPhase != $past(halfPhase));

  // R4
  always_comb begin
    if (!rstOeN) begin
      resetQuiet_chk: assert (outEn == '0 && outVal == '0);
    end
  end

  // R6
  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_off
    offLow_chk: assert property (@(posedge refClk) disable iff (!rstOeN)
      !outEn[i] |-> !outVal[i]);
  end
endmodule

// File: rtl/clk_bank_fanout.sv
module clk_bank_fanout
  import clk_bank_fanout_pkg::*;
#(
  parameter int OUTS_PER_BANK = 5,
  localparam int NUM_OUTS = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                 refClk,
  input  logic                 rstOeN,
  input  logic [CODE_W-1:0]    bankEnCode,
  input  logic [NUM_BANKS-1:0] divSel,
  output logic [NUM_OUTS-1:0]  clkOutEn,
  output logic [NUM_OUTS-1:0]  clkOutVal,
  output logic [NUM_OUTS-1:0]  clkPad
);
  fanoutCtrl_t ctrl;

  fanout_ctrl u_ctrl (
    .refClk     (refClk),
    .rstOeN     (rstOeN),
    .bankEnCode (bankEnCode),
    .divSel     (divSel),
    .ctrl       (ctrl)
  );

  fanout_datapath #(.OUTS_PER_BANK(OUTS_PER_BANK)) u_dp (
    .refClk (refClk),
    .rstOeN (rstOeN),
    .ctrl   (ctrl),
    .outEn  (clkOutEn),
    .outVal (clkOutVal)
  );

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_pad
    assign clkPad[i] = clkOutEn[i] ? clkOutVal[i] : 1'bz;
  end
endmodule

// File: tb/clk_bank_fanout_bench.sv
module clk_bank_fanout_bench;
  localparam int PER  = 5;
  localparam int NB   = 4;
  localparam int NOUT = NB * PER;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      code = 2'b11;
  logic [NB-1:0]   sel = 4'b1111;
  logic [NOUT-1:0] en, val, pad;

  int    vectors = 0;
  int    miscompares = 0;
  int    edges = 0;
  bit    done = 0;
  string scen = "reset";

  clk_bank_fanout #(.OUTS_PER_BANK(PER)) u_clk_bank_fanout (
    .refClk(clk), .rstOeN(rstN), .bankEnCode(code), .divSel(sel),
    .clkOutEn(en), .clkOutVal(val), .clkPad(pad)
  );

  always #5 clk = ~clk;

  // reference: rising edges counted since release
  always @(posedge clk or negedge rstN) begin
    if (!rstN) edges = 0;
    else       edges = edges + 1;
  end

  function automatic int liveCount(input logic [1:0] c);
    if (c == 2'b00) return 1;
    if (c == 2'b10) return 2;
    if (c == 2'b01) return 3;
    return 4;
  endfunction

  task automatic checkNow();
    int   n;
    logic half;
    n    = liveCount(code);
    half = (edges % 2) == 1;
    for (int b = 0; b < NB; b++) begin
      logic eExp, vExp;
      logic [PER-1:0] eGot, vGot, pGot;
      string tagE, tagV;
      eExp = rstN && (b < n);
      vExp = eExp && (sel[b] ? clk : half);
      eGot = en[b*PER +: PER];
      vGot = val[b*PER +: PER];
      pGot = pad[b*PER +: PER];
      tagE = rstN ? "R5" : "R4";
      tagV = !rstN ? "R4" : (!eExp ? "R6" : (sel[b] ? "R2" : "R3"));
      vectors++;
      if (eGot !== {PER{eExp}}) begin
        miscompares++;
        $display("FAIL %s R1 (%s) bank %0d enable got %b exp %b", tagE, scen, b, eGot, {PER{eExp}});
      end
      vectors++;
      if (vGot !== {PER{vExp}}) begin
        miscompares++;
        $display("FAIL %s R1 (%s) bank %0d value got %b exp %b", tagV, scen, b, vGot, {PER{vExp}});
      end
      if (eExp) begin
        vectors++;
        if (pGot !== {PER{vExp}}) begin
          miscompares++;
          $display("FAIL R8 (%s) bank %0d pad got %b exp %b", scen, b, pGot, {PER{vExp}});
        end
      end
    end
  endtask

  // sample 2 ns after each clock edge, at both clock levels
  always @(posedge clk) begin #2; if (!done) checkNow(); end
  always @(negedge clk) begin #2; if (!done) checkNow(); end

  task automatic run(input int cycles);
    repeat (cycles) @(posedge clk);
  endtask

  // inputs change 4 ns after a rising edge
  task automatic drive(input logic r, input logic [1:0] c, input logic [NB-1:0] s);
    @(posedge clk); #4;
    rstN = r; code = c; sel = s;
  endtask

  initial begin
    // R4: reset holds everything off whatever the code and selects
    scen = "reset state R4";
    run(4);
    drive(1'b0, 2'b01, 4'b0000);
    run(3);
    // R3: release into half rate, all banks
    scen = "release half rate R3";
    drive(1'b1, 2'b11, 4'b0000);
    run(10);
    scen = "full rate R2";
    drive(1'b1, 2'b11, 4'b1111);
    run(6);
    scen = "mixed rates R2 R3";
    drive(1'b1, 2'b11, 4'b0101);
    run(6);
    // R5: each enable code
    scen = "code 00 R5";
    drive(1'b1, 2'b00, 4'b1010);
    run(5);
    scen = "code 10 R5";
    drive(1'b1, 2'b10, 4'b1010);
    run(5);
    scen = "code 01 R5";
    drive(1'b1, 2'b01, 4'b0110);
    run(5);
    scen = "code 11 R5";
    drive(1'b1, 2'b11, 4'b1001);
    run(5);
    // R7: rate switch mid-run, no reset
    scen = "select switch R7";
    drive(1'b1, 2'b11, 4'b1111);
    run(3);
    drive(1'b1, 2'b11, 4'b0000);
    run(3);
    drive(1'b1, 2'b11, 4'b0011);
    run(4);
    // R4 then R3: reset mid-run with the divider high, re-release
    scen = "mid-run reset R4";
    @(posedge clk);
    while (edges % 2 == 0) @(posedge clk);
    #4 rstN = 1'b0;
    run(4);
    scen = "re-release R3";
    drive(1'b1, 2'b10, 4'b0100);
    run(8);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired in %s", scen);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule